// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single output line. It sends one bit per clock. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The data width, the parity mode and the stop count are chosen for each frame when the start strobe is accepted. Between frames the line rests high and the ready flag is raised.

A five-state controller sequences each frame. A loadable down-counter counts the data bits, so a single data state serves every frame length. A shift register presents each data bit in turn. A parity flop is preset to the selected parity sense and folds in every bit as it leaves. The final stop bit is the first cycle of the ready state. A new frame can therefore start on that same cycle.

Top module: `ser_frame_tx`

## Requirements
- R1: While reset is high, and on the first cycle after it, `tx_line` is 1 and `ready` is 1.
- R2: When idle, `ready` is 1 and `tx_line` is 1. A high `start` while idle gives a start bit (`tx_line`=0, `ready`=0) on the next cycle.
- R3: After the start bit, the data bits follow one per cycle, least significant bit first. The count is 5, 6, 7 or 8 for `len_sel` codes 0, 1, 2 and 3.
- R4: With `par_en`=1, one parity bit follows the last data bit. It is the XOR of the sent data bits, and it is inverted when `par_odd`=1. `par_odd`=0 gives even parity and `par_odd`=1 gives odd parity.
- R5: With `two_stop`=0 the frame ends in one high cycle, the idle cycle with `ready`=1. With `two_stop`=1 an extra high cycle with `ready`=0 comes before it.
- R6: `din`, `len_sel`, `two_stop`, `par_en` and `par_odd` are taken only in the cycle where `start` is accepted. Later changes do not alter the frame in progress.
- R7: `start` is ignored while a frame is in progress. The bits sent and the frame length are unchanged.
- R8: A `start` in the final idle cycle of a frame begins the next frame on the following cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (acted on only while ready) |
| din | input | 8 | Data word, bit 0 sent first |
| len_sel | input | 2 | Data length code: 0..3 gives 5..8 bits |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| par_en | input | 1 | 1: append a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even |
| tx_line | output | 1 | Serial output, rests at 1 |
| ready | output | 1 | High in the idle state |

## Verification
The bench uses the default parameters, a 2-bit length code and a 5-bit minimum. With these, all four data lengths, 5 to 8 bits, can be reached, and so can every length that loads the counter, including the longest, 8-bit case. Frames are sent with every mix of parity and stop settings. Back-to-back frames are sent, and some frames have `start` pulsed and the configuration inputs scrambled while they are being sent.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_INIT = 3'd1,
        ST_DAT  = 3'd2,
        ST_PAR  = 3'd3,
        ST_STOP = 3'd4
    } sft_state_e;

    typedef struct packed {
        logic two_stop;
        logic par_en;
        logic par_odd;
    } sft_opts_t;

    // highest value the bit counter is ever loaded with
    function automatic int sft_max_load(input int minb, input int lsw);
        return minb + (1 << lsw) - 2;
    endfunction

endpackage

// File: rtl/sft_bit_cnt.sv
module sft_bit_cnt #(
    parameter int LSW  = 2,
    parameter int MINB = 5,
    localparam int CW  = $clog2(sft_pkg::sft_max_load(MINB, LSW) + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           dec,
    input  logic [LSW-1:0] len_sel,
    output logic [CW-1:0]  cnt,
    output logic           last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(MINB - 1) + CW'(len_sel);
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == '0);
endmodule

// File: rtl/sft_shift.sv
module sft_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          init,
    input  logic          shift,
    input  logic [DW-1:0] din,
    input  logic          par_odd,
    output logic          sr_lsb,
    output logic          par_bit
);
    logic [DW-1:0] sr_q;
    logic          par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            par_q <= 1'b0;
        end else begin
            if (capture) begin
                sr_q <= din;
            end else if (shift) begin
                sr_q <= sr_q >> 1;
            end
            if (init) begin
                par_q <= par_odd;
            end else if (shift) begin
                par_q <= par_q ^ sr_q[0];
            end
        end
    end

    assign sr_lsb  = sr_q[0];
    assign par_bit = par_q;
endmodule

// File: rtl/sft_ctrl.sv
module sft_ctrl
    import sft_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       last,
    input  sft_opts_t  opts,
    input  logic       sr_lsb,
    input  logic       par_bit,
    output sft_state_e state,
    output logic       capture,
    output logic       init,
    output logic       shift,
    output logic       tx_line,
    output logic       ready
);
    sft_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_INIT;
            ST_INIT: state_d = ST_DAT;
            ST_DAT: begin
                if (last) begin
                    if (opts.par_en)        state_d = ST_PAR;
                    else if (opts.two_stop) state_d = ST_STOP;
                    else                    state_d = ST_IDLE;
                end
            end
            ST_PAR:  state_d = opts.two_stop ? ST_STOP : ST_IDLE;
            ST_STOP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_INIT: tx_line = 1'b0;
            ST_DAT:  tx_line = sr_lsb;
            ST_PAR:  tx_line = par_bit;
            default: tx_line = 1'b1;
        endcase
    end

    assign state   = state_q;
    assign ready   = (state_q == ST_IDLE);
    assign capture = ready && start;
    assign init    = (state_q == ST_INIT);
    assign shift   = (state_q == ST_DAT);
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
    import sft_pkg::*;
#(
    parameter int LSW  = 2,
    parameter int MINB = 5,
    localparam int DW  = MINB + (1 << LSW) - 1,
    localparam int CW  = $clog2(sft_max_load(MINB, LSW) + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [DW-1:0]  din,
    input  logic [LSW-1:0] len_sel,
    input  logic           two_stop,
    input  logic           par_en,
    input  logic           par_odd,
    output logic           tx_line,
    output logic           ready
);
    sft_state_e     state;
    sft_opts_t      opts_q;
    logic [LSW-1:0] len_q;
    logic           capture, init, shift, last, sr_lsb, par_bit;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            opts_q <= '0;
            len_q  <= '0;
        end else if (capture) begin
            opts_q <= '{two_stop: two_stop, par_en: par_en, par_odd: par_odd};
            len_q  <= len_sel;
        end
    end

    sft_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .last(last), .opts(opts_q),
        .sr_lsb(sr_lsb), .par_bit(par_bit), .state(state),
        .capture(capture), .init(init), .shift(shift),
        .tx_line(tx_line), .ready(ready)
    );

    sft_bit_cnt #(.LSW(LSW), .MINB(MINB)) u_cnt (
        .clk(clk), .rst(rst), .load(init), .dec(shift),
        .len_sel(len_q), .cnt(cnt), .last(last)
    );

    sft_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst(rst), .capture(capture), .init(init), .shift(shift),
        .din(din), .par_odd(opts_q.par_odd), .sr_lsb(sr_lsb), .par_bit(par_bit)
    );
endmodule

// File: rtl/sft_chk.sv
module sft_chk
    import sft_pkg::*;
#(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          tx_line,
    input logic          ready,
    input sft_state_e    state,
    input logic [CW-1:0] cnt
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) $past(rst) |-> (tx_line && ready));

    // R2
    ready_mark_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> tx_line);

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> (!tx_line && !ready));

    // R3
    data_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INIT) |=> (state == ST_DAT));

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DAT && cnt != '0) |=> (state == ST_DAT && (cnt + 1'b1) == $past(cnt)));

    // R5
    stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |-> tx_line ##1 ready);

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> (state != ST_INIT));
endmodule

bind ser_frame_tx sft_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .tx_line(tx_line),
    .ready(ready), .state(state), .cnt(cnt)
);

// File: tb/ser_frame_tx_test.sv
`timescale 1ns/1ps
module ser_frame_tx_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] din = '0;
    logic [1:0] len_sel = '0;
    logic       two_stop = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic       tx_line, ready;

    int n_vec = 0;
    int n_bad = 0;
    bit done_flag = 0;

    typedef struct {
        logic  line;
        logic  rdy;
        string req;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    ser_frame_tx uut (
        .clk(clk), .rst(rst), .start(start), .din(din), .len_sel(len_sel),
        .two_stop(two_stop), .par_en(par_en), .par_odd(par_odd),
        .tx_line(tx_line), .ready(ready)
    );

    task automatic check(input string req, input logic l, input logic r);
        n_vec++;
        if (tx_line !== l || ready !== r) begin
            n_bad++;
            $display("FAIL %s: tx_line=%b ready=%b expected tx_line=%b ready=%b",
                     req, tx_line, ready, l, r);
        end
    endtask

    // monitor: one expected item per cycle while the queue holds any
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t it;
            it = expq.pop_front();
            check(it.req, it.line, it.rdy);
        end
    end

    task automatic push(input logic l, input logic r, input string req);
        exp_t it;
        it.line = l; it.rdy = r; it.req = req;
        expq.push_back(it);
    endtask

    // driver: called just after a negedge while the design is idle
    task automatic send(input logic [7:0] d, input logic [1:0] ls, input logic ns,
                        input logic pe, input logic ps, input bit poke);
        int  nb;
        logic p;
        nb = 5 + int'(ls);
        p  = ps;
        din = d; len_sel = ls; two_stop = ns; par_en = pe; par_odd = ps;
        start = 1'b1;
        push(1'b0, 1'b0, "R2 start bit");
        for (int i = 0; i < nb; i++) begin
            push(d[i], 1'b0, "R3 data bit");
            p = p ^ d[i];
        end
        if (pe) push(p, 1'b0, "R4 parity bit");
        if (ns) push(1'b1, 1'b0, "R5 extra stop bit");
        push(1'b1, 1'b1, "R5 final stop/idle");
        @(posedge clk); #1;
        start = 1'b0;
        // R6: scramble configuration after acceptance
        din = ~d; len_sel = ~ls; two_stop = ~ns; par_en = ~pe; par_odd = ~ps;
        if (poke) begin
            // R7: start pulsed mid-frame
            @(posedge clk); #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        wait (expq.size() == 0);
        #1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", 1'b1, 1'b1);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check("R1 first cycle after reset", 1'b1, 1'b1);
        @(negedge clk);
        check("R2 idle", 1'b1, 1'b1);
        #1;
        // R3 all lengths, no parity, one stop
        send(8'hA5, 2'd0, 1'b0, 1'b0, 1'b0, 0);
        send(8'h3C, 2'd1, 1'b0, 1'b0, 1'b0, 0);
        send(8'hC9, 2'd2, 1'b0, 1'b0, 1'b0, 0);
        send(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 0);
        // R4 parity even / odd, R5 two stop bits
        send(8'hB7, 2'd3, 1'b0, 1'b1, 1'b0, 0);
        send(8'hB7, 2'd3, 1'b0, 1'b1, 1'b1, 0);
        send(8'h1F, 2'd0, 1'b1, 1'b1, 1'b0, 0);
        send(8'h6E, 2'd2, 1'b1, 1'b0, 1'b1, 0);
        send(8'h00, 2'd1, 1'b1, 1'b1, 1'b1, 0);
        // R6 / R7 mid-frame start pulses and scrambled inputs
        send(8'h5A, 2'd3, 1'b1, 1'b1, 1'b0, 1);
        send(8'hFF, 2'd0, 1'b0, 1'b1, 1'b1, 1);
        // R8 back-to-back frames: send starts in the final idle cycle
        for (int k = 0; k < 8; k++) begin
            send(8'(k * 37 + 11), 2'(k), k[1], k[0], k[2], 0);
        end
        repeat (2) @(negedge clk);
        check("R2 idle after traffic", 1'b1, 1'b1);
        done_flag = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule